// File: doc/BRIEF.md
# Serial Receiver with Line-Break Wake-up

This block receives asynchronous serial characters on a single input line. It takes 16 samples per bit period and reads each bit at its centre. Each character has a low start bit, 8 or 9 data bits sent least significant bit first, and a high stop bit. Received characters go into a two-entry first-word-fall-through queue. Each entry keeps its own framing-error flag. When a character completes while the queue is full, the block sets a sticky overrun flag.

Software can also arm a wake-up mode. While this mode is armed, character decoding stops and the block only watches the line. It uses a synchronizer that does not depend on the baud generator. The first high-to-low transition raises a pending wake event, which drives the interrupt. The mode disarms itself on the next low-to-high transition, and normal reception then resumes. A read strobe pops the queue and acknowledges a pending wake event.

Top module: `uart_wake_rx`

## Requirements
- R1: After reset, `irq_o`, `rx_valid_o`, `overrun_o` and `wake_armed_o` are all low.
- R2: A frame consists of a low start bit, the data bits LSB first and a high stop bit. While `rx_en_i` is high it is captured and shown on `rd_data_o` with `rx_valid_o` high. A cycle with `rd_i` high pops the entry.
- R3: With `nine_bit_i` high the frame carries 9 data bits, and the ninth appears on `rd_data_o[8]`. With `nine_bit_i` low, 8 bits are received and `rd_data_o[8]` reads 0.
- R4: If a frame's stop bit samples low, the byte is still stored, and `frame_err_o` is high while that entry is at the head of the queue. Entries with a high stop bit show it low.
- R5: The queue holds two characters and returns them in arrival order.
- R6: If a frame completes while two entries are unread, `overrun_o` is set and that character is lost. While `overrun_o` is high, every further character is dropped. `overrun_o` clears only in the cycle after `rx_en_i` is low.
- R7: With `rx_en_i` low, frames on the line store nothing.
- R8: A low pulse shorter than half a bit period is rejected as a false start and stores nothing.
- R9: `wake_set_i` arms the wake mode (`wake_armed_o` high). While it is armed, no character is decoded. The first falling edge of `rx_i` raises `irq_o` on the third rising clock edge after the change, whatever the baud divisor.
- R10: The armed mode stays set while the line is low after the wake event. It clears itself once the line returns high, and later frames are then received normally.
- R11: `irq_o` is high while the queue is non-empty or a wake event is pending. A cycle with `rd_i` high acknowledges the pending wake event.
- R12: Oversample ticks occur every `baud_div_i`+1 clock cycles, so a bit lasts 16*(`baud_div_i`+1) cycles. Reception works at divisors 0, 3 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial receive line, idle high |
| baud_div_i | input | DIV_W | Oversample divisor; tick period is value+1 cycles |
| rx_en_i | input | 1 | Receive enable; low also clears overrun |
| nine_bit_i | input | 1 | Selects 9 data bits per frame |
| wake_set_i | input | 1 | Pulse that arms the wake-up mode |
| rd_i | input | 1 | Read strobe: pops the queue head and acknowledges a wake event |
| rd_data_o | output | 9 | Queue head data, zero when empty |
| frame_err_o | output | 1 | Framing error of the queue head |
| rx_valid_o | output | 1 | Queue holds at least one character |
| overrun_o | output | 1 | Sticky overrun flag |
| irq_o | output | 1 | Receive interrupt |
| wake_armed_o | output | 1 | Wake-up mode armed |

## Verification
The checker assumes that every level on `rx_i` lasts more than one clock, so a rising edge is still visible when the armed mode drops. It also assumes that `wake_set_i` is pulsed only while the line is idle high. The bench drives every line change on the falling clock edge and holds each level for whole bit periods, or for a deliberately short glitch of several ticks. It changes `rx_en_i`, `nine_bit_i` and `baud_div_i` only between frames. Reads and arming pulses are issued only while no frame is in flight, so the reference model can update at frame boundaries and be compared on every quiet clock.

// File: rtl/uart_wake_rx_pkg.sv
package uart_wake_rx_pkg;
  localparam int unsigned DATA_MAX = 9;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} rx_state_e;

  typedef struct packed {
    logic                ferr;
    logic [DATA_MAX-1:0] data;
  } rx_word_t;
endpackage

// File: rtl/uart_wake_rx_sync.sv
module uart_wake_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic rx_o,
  output logic fall_o,
  output logic rise_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      prev_q <= 1'b1;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], rx_i};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign rx_o   = sh_q[STAGES-1];
  assign fall_o = prev_q & ~rx_o;
  assign rise_o = ~prev_q & rx_o;
endmodule

// File: rtl/uart_wake_rx_baud.sv
module uart_wake_rx_baud #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             clr_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i || cnt_q == '0)     cnt_q <= div_i;
    else                               cnt_q <= cnt_q - 1'b1;
  end

  assign tick_o = (cnt_q == '0) && !clr_i;
endmodule

// File: rtl/uart_wake_rx_frame.sv
module uart_wake_rx_frame
  import uart_wake_rx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  logic     nine_bit_i,
  input  logic     rx_i,
  input  logic     fall_i,
  input  logic     tick_i,
  output logic     clr_o,
  output logic     push_o,
  output rx_word_t word_o
);
  localparam int unsigned SUB_W = $clog2(OVS);
  localparam logic [SUB_W-1:0] SUB_MID = SUB_W'(OVS / 2 - 1);
  localparam logic [SUB_W-1:0] SUB_END = SUB_W'(OVS - 1);
  localparam int unsigned BIT_W = $clog2(DATA_MAX);

  rx_state_e           state_q;
  logic [SUB_W-1:0]    sub_q;
  logic [BIT_W-1:0]    bit_q;
  logic [DATA_MAX-1:0] sh_q;
  logic [BIT_W-1:0]    last_bit;

  assign last_bit = nine_bit_i ? BIT_W'(DATA_MAX - 1) : BIT_W'(DATA_MAX - 2);
  assign clr_o    = en_i && (state_q == ST_IDLE) && fall_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sub_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      push_o  <= 1'b0;
      word_o  <= '0;
    end else begin
      push_o <= 1'b0;
      if (!en_i) begin
        state_q <= ST_IDLE;
        sub_q   <= '0;
      end else begin
        unique case (state_q)
          ST_IDLE: begin
            if (fall_i) begin
              state_q <= ST_START;
              sub_q   <= '0;
            end
          end
          ST_START: begin
            if (tick_i) begin
              if (sub_q == SUB_MID) begin
                sub_q   <= '0;
                bit_q   <= '0;
                state_q <= rx_i ? ST_IDLE : ST_DATA;  // false start rejected
              end else begin
                sub_q <= sub_q + 1'b1;
              end
            end
          end
          ST_DATA: begin
            if (tick_i) begin
              if (sub_q == SUB_END) begin
                sub_q <= '0;
                sh_q  <= {rx_i, sh_q[DATA_MAX-1:1]};
                if (bit_q == last_bit) state_q <= ST_STOP;
                else                   bit_q   <= bit_q + 1'b1;
              end else begin
                sub_q <= sub_q + 1'b1;
              end
            end
          end
          ST_STOP: begin
            if (tick_i) begin
              if (sub_q == SUB_END) begin
                sub_q       <= '0;
                push_o      <= 1'b1;
                word_o.ferr <= ~rx_i;
                word_o.data <= nine_bit_i ? sh_q : {1'b0, sh_q[DATA_MAX-1:1]};
                state_q     <= ST_IDLE;
              end else begin
                sub_q <= sub_q + 1'b1;
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_wake_rx_fifo.sv
module uart_wake_rx_fifo
  import uart_wake_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 2,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  rx_word_t         word_i,
  input  logic             pop_i,
  output rx_word_t         head_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [CNT_W-1:0] count_o
);
  rx_word_t         mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_wr, do_rd;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign do_rd   = pop_i && !empty_o;
  assign do_wr   = push_i && (!full_o || do_rd);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (do_wr) begin
        mem_q[wr_q] <= word_i;
        wr_q        <= ptr_next(wr_q);
      end
      if (do_rd) rd_q <= ptr_next(rd_q);
      cnt_q <= cnt_q + CNT_W'(do_wr) - CNT_W'(do_rd);
    end
  end

  assign head_o  = mem_q[rd_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/uart_wake_rx.sv
module uart_wake_rx
  import uart_wake_rx_pkg::*;
#(
  parameter int unsigned DIV_W       = 16,
  parameter int unsigned FIFO_DEPTH  = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned OVS         = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rx_i,
  input  logic [DIV_W-1:0]    baud_div_i,
  input  logic                rx_en_i,
  input  logic                nine_bit_i,
  input  logic                wake_set_i,
  input  logic                rd_i,
  output logic [DATA_MAX-1:0] rd_data_o,
  output logic                frame_err_o,
  output logic                rx_valid_o,
  output logic                overrun_o,
  output logic                irq_o,
  output logic                wake_armed_o
);
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1);

  logic             rx_s, rx_fall, rx_rise;
  logic             baud_clr, baud_tick;
  logic             frm_en, frm_push;
  rx_word_t         frm_word, head;
  logic             fifo_push, fifo_pop, fifo_empty, fifo_full;
  logic [CNT_W-1:0] fifo_cnt;
  logic             overrun_q;
  logic             wake_armed_q, wake_seen_q, wake_pend_q;

  uart_wake_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .rx_i,
    .rx_o(rx_s), .fall_o(rx_fall), .rise_o(rx_rise)
  );

  uart_wake_rx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk_i, .rst_ni, .div_i(baud_div_i), .clr_i(baud_clr), .tick_o(baud_tick)
  );

  assign frm_en = rx_en_i && !wake_armed_q;

  uart_wake_rx_frame #(.OVS(OVS)) u_frame (
    .clk_i, .rst_ni, .en_i(frm_en), .nine_bit_i, .rx_i(rx_s), .fall_i(rx_fall),
    .tick_i(baud_tick), .clr_o(baud_clr), .push_o(frm_push), .word_o(frm_word)
  );

  assign fifo_pop  = rd_i && !fifo_empty;
  assign fifo_push = frm_push && !overrun_q;

  uart_wake_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni, .push_i(fifo_push), .word_i(frm_word), .pop_i(fifo_pop),
    .head_o(head), .empty_o(fifo_empty), .full_o(fifo_full), .count_o(fifo_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                       overrun_q <= 1'b0;
    else if (!rx_en_i)                                 overrun_q <= 1'b0;
    else if (frm_push && fifo_full && !fifo_pop)       overrun_q <= 1'b1;
  end

  // Wake mode: edge-driven, independent of the baud tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wake_armed_q <= 1'b0;
      wake_seen_q  <= 1'b0;
      wake_pend_q  <= 1'b0;
    end else begin
      if (!wake_armed_q) begin
        if (wake_set_i) begin
          wake_armed_q <= 1'b1;
          wake_seen_q  <= 1'b0;
        end
      end else if (!wake_seen_q && rx_fall) begin
        wake_seen_q <= 1'b1;
      end else if (wake_seen_q && rx_rise) begin
        wake_armed_q <= 1'b0;
        wake_seen_q  <= 1'b0;
      end

      if (wake_armed_q && !wake_seen_q && rx_fall) wake_pend_q <= 1'b1;
      else if (rd_i)                               wake_pend_q <= 1'b0;
    end
  end

  assign rd_data_o    = fifo_empty ? '0 : head.data;
  assign frame_err_o  = !fifo_empty && head.ferr;
  assign rx_valid_o   = !fifo_empty;
  assign overrun_o    = overrun_q;
  assign irq_o        = !fifo_empty || wake_pend_q;
  assign wake_armed_o = wake_armed_q;
endmodule

// File: rtl/uart_wake_rx_chk.sv
module uart_wake_rx_chk #(
  parameter int unsigned DEPTH = 2,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rx_en_i,
  input logic             overrun_o,
  input logic             wake_armed_o,
  input logic             irq_o,
  input logic             rx_valid_o,
  input logic             push_i,
  input logic             fall_i,
  input logic             rx_s_i,
  input logic [CNT_W-1:0] cnt_i
);
  a_r6_overrun_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o && rx_en_i |=> overrun_o);

  a_r6_overrun_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> !overrun_o);

  a_r9_no_decode_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_armed_o && $past(wake_armed_o) |-> !push_i);

  a_r9_wake_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_armed_o && fall_i |=> irq_o);

  a_r10_disarm_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wake_armed_o) |-> rx_s_i);

  a_r5_fifo_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CNT_W'(DEPTH));

  a_r2_valid_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o == (cnt_i != '0));

  a_r11_irq_on_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> irq_o);
endmodule

bind uart_wake_rx uart_wake_rx_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rx_en_i(rx_en_i), .overrun_o(overrun_o),
  .wake_armed_o(wake_armed_o), .irq_o(irq_o), .rx_valid_o(rx_valid_o),
  .push_i(frm_push), .fall_i(rx_fall), .rx_s_i(rx_s), .cnt_i(fifo_cnt)
);

// File: tb/uart_wake_rx_test.sv
module uart_wake_rx_test;
  logic        clk = 1'b0, rst_n = 1'b0, rx = 1'b1, rx_en = 1'b0, nine = 1'b0;
  logic        wset = 1'b0, rd = 1'b0;
  logic [15:0] div = 16'd3;
  logic [8:0]  rd_data;
  logic        ferr, valid, ovr, irq, armed;

  int    n_cmp = 0, n_bad = 0;
  bit    stable = 1'b0;
  int    q[$];
  bit    m_ovr = 1'b0, m_pend = 1'b0, m_armed = 1'b0;
  string phase = "R1";

  uart_wake_rx uut (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .baud_div_i(div), .rx_en_i(rx_en),
    .nine_bit_i(nine), .wake_set_i(wset), .rd_i(rd), .rd_data_o(rd_data),
    .frame_err_o(ferr), .rx_valid_o(valid), .overrun_o(ovr), .irq_o(irq),
    .wake_armed_o(armed)
  );

  always #4 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s [%s] act=%0h exp=%0h t=%0t", tag, phase, act, exp, $time);
    end
  endtask

  // Reference model comparison on every quiet clock
  always @(negedge clk) begin
    if (stable && rst_n) begin
      chk("R11 irq", int'(irq), int'((q.size() != 0) || m_pend));
      chk("R5 valid", int'(valid), int'(q.size() != 0));
      chk("R6 overrun", int'(ovr), int'(m_ovr));
      chk("R10 armed", int'(armed), int'(m_armed));
      if (q.size() != 0) begin
        chk("R2 data", int'(rd_data), q[0] & 'h1ff);
        chk("R4 ferr", int'(ferr), (q[0] >> 9) & 1);
      end
    end
  end

  task automatic drive(input logic v, input int n);
    rx = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input int data, input int nb, input bit stop_v);
    int bp;
    bp = 16 * (int'(div) + 1);
    @(negedge clk);
    stable = 1'b0;
    drive(1'b0, bp);
    for (int i = 0; i < nb; i++) drive(logic'((data >> i) & 1), bp);
    drive(stop_v, bp);
    drive(1'b1, bp);
    if (rx_en && !m_ovr) begin
      if (q.size() == 2) m_ovr = 1'b1;
      else q.push_back((data & ((1 << nb) - 1)) | (stop_v ? 0 : 'h200));
    end
    stable = 1'b1;
  endtask

  task automatic read_word(string tag, input int exp);
    @(negedge clk);
    if (exp >= 0) begin
      chk({tag, " valid"}, int'(valid), 1);
      chk({tag, " word"}, int'({ferr, rd_data}), exp);
    end
    rd = 1'b1;
    @(posedge clk);
    if (q.size() != 0) void'(q.pop_front());
    m_pend = 1'b0;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic set_en(input logic v);
    @(negedge clk);
    rx_en = v;
    @(posedge clk);
    if (!v) m_ovr = 1'b0;
    @(negedge clk);
  endtask

  task automatic arm();
    @(negedge clk);
    wset = 1'b1;
    @(posedge clk);
    m_armed = 1'b1;
    @(negedge clk);
    wset = 1'b0;
  endtask

  task automatic wake_break(input int low_cycles);
    @(negedge clk);
    stable = 1'b0;
    rx = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 irq not before third edge", int'(irq), int'(q.size() != 0));
    @(negedge clk);
    m_pend = 1'b1;
    chk("R9 irq on third edge", int'(irq), 1);
    stable = 1'b1;
    repeat (low_cycles) @(negedge clk);
    chk("R10 still armed while low", int'(armed), 1);
    stable = 1'b0;
    rx = 1'b1;
    repeat (4) @(negedge clk);
    m_armed = 1'b0;
    chk("R10 disarmed after rise", int'(armed), 0);
    stable = 1'b1;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog all-requirements act=timeout exp=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq", int'(irq), 0);
    chk("R1 valid", int'(valid), 0);
    chk("R1 overrun", int'(ovr), 0);
    chk("R1 armed", int'(armed), 0);
    stable = 1'b1;
    set_en(1'b1);

    phase = "R2";
    send('hA5, 8, 1'b1);
    chk("R2 valid after frame", int'(valid), 1);
    read_word("R2", 'h0A5);
    chk("R2 empty after pop", int'(valid), 0);

    phase = "R5";
    send('h3C, 8, 1'b1);
    send('h81, 8, 1'b1);
    read_word("R5 first", 'h03C);
    read_word("R5 second", 'h081);

    phase = "R3";
    nine = 1'b1;
    send('h1A5, 9, 1'b1);
    read_word("R3 nine", 'h1A5);
    send('h0F0, 9, 1'b1);
    read_word("R3 nine low msb", 'h0F0);
    nine = 1'b0;
    send('hFF, 8, 1'b1);
    read_word("R3 eight bit8 zero", 'h0FF);

    phase = "R4";
    send('h5A, 8, 1'b0);
    send('h33, 8, 1'b1);
    read_word("R4 ferr entry", 'h25A);
    read_word("R4 clean entry", 'h033);

    phase = "R6";
    send('h11, 8, 1'b1);
    send('h22, 8, 1'b1);
    send('h33, 8, 1'b1);
    chk("R6 overrun set", int'(ovr), 1);
    send('h44, 8, 1'b1);
    read_word("R6 keep1", 'h011);
    read_word("R6 keep2", 'h022);
    chk("R6 dropped third", int'(valid), 0);
    chk("R6 sticky", int'(ovr), 1);
    send('h55, 8, 1'b1);
    chk("R6 drop while set", int'(valid), 0);
    set_en(1'b0);
    chk("R6 cleared by disable", int'(ovr), 0);
    set_en(1'b1);
    send('h66, 8, 1'b1);
    read_word("R6 after clear", 'h066);

    phase = "R7";
    set_en(1'b0);
    send('h77, 8, 1'b1);
    chk("R7 disabled nothing", int'(valid), 0);
    set_en(1'b1);

    phase = "R8";
    @(negedge clk);
    stable = 1'b0;
    drive(1'b0, 3 * (int'(div) + 1));
    drive(1'b1, 40 * (int'(div) + 1));
    stable = 1'b1;
    chk("R8 glitch rejected", int'(valid), 0);
    send('h99, 8, 1'b1);
    read_word("R8 after glitch", 'h099);

    phase = "R12";
    div = 16'd7;
    send('hC3, 8, 1'b1);
    read_word("R12 div7", 'h0C3);
    div = 16'd0;
    send('h5E, 8, 1'b1);
    read_word("R12 div0", 'h05E);
    div = 16'd3;

    phase = "R9";
    send('h12, 8, 1'b1);
    arm();
    chk("R9 armed", int'(armed), 1);
    wake_break(200);
    chk("R9 break not decoded", int'(valid), 1);
    read_word("R9 only prior byte", 'h012);
    chk("R11 irq low after read", int'(irq), 0);

    phase = "R10";
    send('h6D, 8, 1'b1);
    read_word("R10 resumed", 'h06D);

    phase = "R11";
    div = 16'd7;
    arm();
    wake_break(60);
    chk("R11 irq from wake only", int'(irq), 1);
    read_word("R11 ack", -1);
    chk("R11 irq cleared by read", int'(irq), 0);
    send('h2B, 8, 1'b1);
    read_word("R11 normal after wake", 'h02B);

    repeat (5) @(negedge clk);
    summary();
    $finish;
  end
endmodule